// File: doc/BRIEF.md
# Pattern-Driven Resampling Tap Sequencer

This block sequences one axis of a pixel scaler. Software programs a batch length (one to eight iterations) and an eight-bit take mask. Once enabled, the block walks through the iterations of a batch. On each iteration the mask bit at the current iteration index decides whether a fresh pixel is pulled from the input stream. Every iteration then emits one pixel on the output stream: the pixel most recently pulled. Two instances serve a scaler, one stepping down rows and one stepping across columns. Each has its own enable.

The control is a three-state machine. `IDLE` waits for the enable bit. Its transition *start* loads the staged settings and enters `TAP`. `TAP` is one iteration's decision point. Its transition *pull* fires when the mask bit is set and an input pixel is offered; the pixel is captured and the machine moves to `EMIT`. Its transition *skip* fires when the mask bit is clear; the machine moves to `EMIT` with the held pixel. While the bit is set and no input is offered, `TAP` stalls. `EMIT` presents the pixel until the consumer accepts it. It then takes one of three transitions: *next* (more iterations remain; go to `TAP`), *wrap* (the batch is done and the block is enabled; reload the settings and go to `TAP`), or *stop* (the batch is done and the block is disabled; go to `IDLE`).

Register writes land in staging registers. The running sequence copies them only at *start*, *wrap* or *stop*, so a batch never sees a setting change partway through.

Top module: `tap_sequencer`

## Requirements
- R1: After reset, `out_valid` and `in_ready` are low, the block is idle, and the held pixel is zero.
- R2: A write to address 0 keeps `cfg_wdata[2:0]` as the batch length minus one. Each batch emits exactly that length of output pixels.
- R3: A write to address 1 keeps `cfg_wdata[7:0]` as the take mask. Bits 31..8 of the write data have no effect on the output sequence.
- R4: On an iteration whose mask bit (bit i for iteration i) is set, exactly one input pixel is accepted. The pixel emitted for that iteration equals the accepted pixel.
- R5: On an iteration whose mask bit is clear, `in_ready` stays low. The emitted pixel repeats the last accepted pixel, or zero if none has been accepted since reset.
- R6: Mask bits at indexes at or above the batch length are ignored. The pixels accepted per batch equal the number of set mask bits below the batch length.
- R7: While the current mask bit is set and no input has been accepted for the iteration, `out_valid` stays low.
- R8: Once `out_valid` is high it stays high, with `out_data` unchanged, until `out_ready` is seen.
- R9: After the last iteration of a batch is accepted, the next iteration is iteration 0 of a new batch using the settings staged at that moment.
- R10: Bit 0 of a write to address 2 is the enable. When the enable is cleared the current batch completes. After that, `in_ready` and `out_valid` stay low until the enable is set again.
- R11: Length, mask and enable writes made during a batch take effect only at the next batch boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address: 0 length-1, 1 mask, 2 enable |
| cfg_wdata | input | 32 | Register write data |
| in_valid | input | 1 | Input pixel offered |
| in_ready | output | 1 | Block accepts the input pixel |
| in_data | input | DATA_W | Input pixel |
| out_valid | output | 1 | Output pixel presented |
| out_ready | input | 1 | Consumer accepts the output pixel |
| out_data | output | DATA_W | Output pixel |

## Verification
An all-clear mask tells a held-pixel repeat apart from a wrong pull, and run straight after reset it exposes the zero initial pixel. A full mask shows one pull per iteration. A sparse mask with set bits above the batch length separates honouring those bits from ignoring them. A starved input with a set bit isolates the stall, and writes landing mid-batch distinguish boundary-timed updates from immediate ones. Random lengths, masks, valid and ready gaps then mix skips, stalls and back-pressure, with every output compared against a bench model of the iteration walk.

// File: rtl/tap_seq_pkg.sv
package tap_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TAP  = 2'd1,
        ST_EMIT = 2'd2
    } tap_state_e;

    localparam logic [1:0] REG_LEN  = 2'd0;
    localparam logic [1:0] REG_MASK = 2'd1;
    localparam logic [1:0] REG_CTRL = 2'd2;
endpackage

// File: rtl/tap_seq_regs.sv
module tap_seq_regs
    import tap_seq_pkg::*;
#(
    parameter int MAX_TAPS = 8,
    parameter int IDX_W    = $clog2(MAX_TAPS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [1:0]          cfg_addr,
    input  logic [31:0]         cfg_wdata,
    output logic [IDX_W-1:0]    stg_len_m1,
    output logic [MAX_TAPS-1:0] stg_mask,
    output logic                stg_en
);
    logic unused_wdata;
    assign unused_wdata = ^cfg_wdata;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_len_m1 <= '0;
            stg_mask   <= '1;
            stg_en     <= 1'b0;
        end else if (cfg_we) begin
            unique case (cfg_addr)
                REG_LEN:  stg_len_m1 <= cfg_wdata[IDX_W-1:0];
                REG_MASK: stg_mask   <= cfg_wdata[MAX_TAPS-1:0];
                REG_CTRL: stg_en     <= cfg_wdata[0];
                default:  ;
            endcase
        end
    end

    // R3: only the low mask bits of the write are kept
    a_r3_mask_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == REG_MASK) |=> (stg_mask == $past(cfg_wdata[MAX_TAPS-1:0])));
endmodule

// File: rtl/tap_seq_iter.sv
module tap_seq_iter #(
    parameter int MAX_TAPS = 8,
    parameter int IDX_W    = $clog2(MAX_TAPS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                advance,
    input  logic [IDX_W-1:0]    stg_len_m1,
    input  logic [MAX_TAPS-1:0] stg_mask,
    output logic                tap_bit,
    output logic                last
);
    logic [IDX_W-1:0]    idx;
    logic [IDX_W-1:0]    sh_len_m1;
    logic [MAX_TAPS-1:0] sh_mask;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx       <= '0;
            sh_len_m1 <= '0;
            sh_mask   <= '0;
        end else if (load) begin
            idx       <= '0;
            sh_len_m1 <= stg_len_m1;
            sh_mask   <= stg_mask;
        end else if (advance) begin
            idx <= idx + 1'b1;
        end
    end

    assign tap_bit = sh_mask[idx];
    assign last    = (idx == sh_len_m1);

    // R9: a boundary restarts the walk at iteration 0
    a_r9_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (idx == '0));
    // R6: the index never reaches bits beyond the batch length
    a_r6_index_in_batch: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= sh_len_m1);
    // R11: the active settings only change at a boundary
    a_r11_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(sh_mask) && $stable(sh_len_m1)));
    // R2: each accepted non-final output moves to the next iteration
    a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load) |=> (idx == $past(idx) + 1'b1));
endmodule

// File: rtl/tap_seq_fsm.sv
module tap_seq_fsm
    import tap_seq_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stg_en,
    input  logic              tap_bit,
    input  logic              last,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              out_ready,
    output logic              in_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              load,
    output logic              advance
);
    tap_state_e state, state_nx;
    logic       capture;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (stg_en) state_nx = ST_TAP;
            ST_TAP:  if (!tap_bit || in_valid) state_nx = ST_EMIT;
            ST_EMIT: if (out_ready) begin
                         if (!last)      state_nx = ST_TAP;
                         else if (stg_en) state_nx = ST_TAP;
                         else            state_nx = ST_IDLE;
                     end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        load      = 1'b0;
        advance   = 1'b0;
        capture   = 1'b0;
        unique case (state)
            ST_IDLE: load = stg_en;
            ST_TAP: begin
                in_ready = tap_bit;
                capture  = tap_bit && in_valid;
            end
            ST_EMIT: begin
                out_valid = 1'b1;
                load      = out_ready && last;
                advance   = out_ready && !last;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       out_data <= '0;
        else if (capture) out_data <= in_data;
    end

    // R8: a presented pixel holds until it is taken
    a_r8_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    // R7: a set bit with no input offered produces no output
    a_r7_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TAP && tap_bit && !in_valid) |=> !out_valid);
    // R5: input is never requested on a clear bit
    a_r5_no_pull_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> tap_bit);
    // R10: a final output with the enable cleared leaves the block quiet
    a_r10_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && last && !stg_en) |=> (!out_valid && !in_ready));
endmodule

// File: rtl/tap_sequencer.sv
module tap_sequencer
    import tap_seq_pkg::*;
#(
    parameter int DATA_W   = 24,
    parameter int MAX_TAPS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);
    localparam int IDX_W = $clog2(MAX_TAPS);

    logic [IDX_W-1:0]    stg_len_m1;
    logic [MAX_TAPS-1:0] stg_mask;
    logic                stg_en;
    logic                tap_bit;
    logic                last;
    logic                load;
    logic                advance;

    tap_seq_regs #(.MAX_TAPS(MAX_TAPS), .IDX_W(IDX_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .stg_len_m1 (stg_len_m1),
        .stg_mask   (stg_mask),
        .stg_en     (stg_en)
    );

    tap_seq_iter #(.MAX_TAPS(MAX_TAPS), .IDX_W(IDX_W)) u_iter (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .advance    (advance),
        .stg_len_m1 (stg_len_m1),
        .stg_mask   (stg_mask),
        .tap_bit    (tap_bit),
        .last       (last)
    );

    tap_seq_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .stg_en    (stg_en),
        .tap_bit   (tap_bit),
        .last      (last),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .load      (load),
        .advance   (advance)
    );
endmodule

// File: tb/sim_tap_sequencer.sv
module sim_tap_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [DW-1:0] in_data = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [DW-1:0] out_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    tap_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data)
    );

    int checks = 0;
    int errors = 0;
    string tag = "";

    // bench model of the iteration walk
    bit            m_en = 0, m_run = 0, m_got = 0;
    int            m_slen = 0, m_alen = 0, m_idx = 0, m_bin = 0;
    logic [7:0]    m_smask = 8'hFF, m_amask = 8'h00;
    logic [DW-1:0] m_last = '0;
    bit            p_valid = 0, p_ready = 0;
    logic [DW-1:0] p_data = '0;
    int            outs_seen = 0;

    task automatic check(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int taps_set(logic [7:0] m, int len_m1);
        int n = 0;
        for (int i = 0; i <= len_m1; i++) n += m[i];
        return n;
    endfunction

    task automatic do_cycle();
        bit was_run = m_run;
        string t;
        if (!m_run) begin
            check(!out_valid && !in_ready, "R10", {out_valid, in_ready}, 0);
        end else if (m_amask[m_idx] && !m_got) begin
            check(!out_valid, "R7", out_valid, 0);
        end
        if (m_run && in_ready && !m_amask[m_idx])
            check(0, "R5", in_ready, 0);
        if (p_valid && !p_ready)
            check(out_valid && out_data == p_data, "R8", out_data, p_data);
        if (in_valid && in_ready) begin
            if (m_got) check(0, "R4", 2, 1);
            m_last = in_data; m_got = 1; m_bin++;
        end
        if (out_valid && out_ready && m_run) begin
            if (tag != "") t = tag;
            else if (m_idx == 0) t = "R9";
            else t = m_amask[m_idx] ? "R4" : "R5";
            check(out_data == m_last, t, out_data, m_last);
            outs_seen++;
            m_got = 0;
            if (m_idx == m_alen) begin
                check(m_bin == taps_set(m_amask, m_alen), "R6", m_bin, taps_set(m_amask, m_alen));
                m_idx = 0; m_bin = 0; m_alen = m_slen; m_amask = m_smask;
                if (!m_en) m_run = 0;
            end else m_idx++;
        end
        if (!was_run && m_en) begin
            m_run = 1; m_idx = 0; m_bin = 0; m_got = 0;
            m_alen = m_slen; m_amask = m_smask;
        end
        if (cfg_we) begin
            case (cfg_addr)
                2'd0: m_slen = int'(cfg_wdata[2:0]);
                2'd1: m_smask = cfg_wdata[7:0];
                2'd2: m_en = cfg_wdata[0];
                default: ;
            endcase
        end
        p_valid = out_valid; p_ready = out_ready; p_data = out_data;
        @(negedge clk);
    endtask

    task automatic run(int cycles, int pv, int pr, int pw);
        for (int c = 0; c < cycles; c++) begin
            logic [31:0] r = $urandom();
            in_valid = ($urandom() % 100) < pv;
            in_data = r[DW-1:0];
            out_ready = ($urandom() % 100) < pr;
            cfg_we = 1'b0;
            if (($urandom() % 1000) < pw) begin
                cfg_we = 1'b1;
                cfg_addr = 2'($urandom() % 3);
                cfg_wdata = $urandom();
                if (cfg_addr == 2'd2) cfg_wdata[0] = ($urandom() % 8) != 0;
            end
            do_cycle();
        end
        cfg_we = 1'b0;
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        in_valid = 1'b0; out_ready = 1'b0;
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        do_cycle();
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check(!out_valid && !in_ready && out_data == '0, "R1", {out_valid, in_ready, out_data}, 0);
        // R5: clear mask straight after reset repeats the zero pixel
        tag = "R5";
        wr(2'd0, 32'd2); wr(2'd1, 32'h0); wr(2'd2, 32'd1);
        run(30, 100, 100, 0);
        wr(2'd2, 32'd0); run(20, 100, 100, 0);
        // R2: length 4, full mask
        tag = "R2";
        wr(2'd0, 32'd3); wr(2'd1, 32'hFF);
        outs_seen = 0;
        wr(2'd2, 32'd1); run(20, 100, 100, 0);
        wr(2'd2, 32'd0); run(20, 100, 100, 0);
        check(outs_seen % 4 == 0 && outs_seen > 0, "R2", outs_seen, 4);
        // R3 and R6: upper write bits, mask bits above the length
        tag = "R3";
        wr(2'd0, 32'd2); wr(2'd1, 32'hDEADBEF5);
        wr(2'd2, 32'd1); run(40, 80, 80, 0);
        wr(2'd2, 32'd0); run(30, 100, 100, 0);
        // R7: set bit with starved input
        tag = "R7";
        wr(2'd0, 32'd1); wr(2'd1, 32'h03);
        outs_seen = 0;
        wr(2'd2, 32'd1); run(30, 0, 100, 0);
        check(outs_seen == 0 && !out_valid, "R7", outs_seen, 0);
        run(20, 100, 100, 0);
        // R11: writes mid-batch wait for the boundary
        tag = "R11";
        wr(2'd0, 32'd7); wr(2'd1, 32'hA5);
        run(5, 100, 100, 0);
        wr(2'd1, 32'h3C); run(3, 100, 100, 0);
        wr(2'd0, 32'd4); run(40, 90, 90, 0);
        // R10: disable mid-batch completes the batch then idles
        tag = "R10";
        wr(2'd2, 32'd0); run(40, 100, 100, 0);
        check(!out_valid && !in_ready, "R10", {out_valid, in_ready}, 0);
        // random mix
        tag = "";
        wr(2'd2, 32'd1);
        run(30000, 70, 70, 15);
        wr(2'd2, 32'd1);
        run(20000, 90, 40, 5);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule